// File: doc/BRIEF.md
# Interrupt-capable GPIO register controller

This block is a sixteen-pin general-purpose I/O peripheral seen by software as a small bank of 16-bit registers behind a plain address / write-enable / read-enable port. Each pin can be turned into an output through a direction register. Output values are never written directly: separate write-one set and write-one clear strobes change only the bits written as 1, and the resulting output word can be read back. Input pins pass through a two-flop synchronizer and can be read as a data-in word.

Every pin owns an event detector. Its mode is decoded into one of three named states: `DET_EDGE` (level-select 0; the rising and falling enables act independently, both together catch both edges), `DET_LEVEL_HI` and `DET_LEVEL_LO` (level-select 1, chosen by the polarity bit). The decoded mode selects the next-pending rule with a `unique case`: in `DET_EDGE` an event sets the pending bit and it stays set until acknowledged; in the level states the pending bit follows the live level and is re-asserted one cycle after an acknowledge while the level stays active. Pending bits are gated by a per-pin mask (1 blocks) and a per-pin enable (1 passes) into a masked status word, whose OR is registered onto a single interrupt line. Software reads the masked status and writes the same value to the acknowledge register.

The register decoder maps the address onto a named register identifier (`RID_NONE` for unmapped addresses); writes act in the cycle after which the addressed register changes, and read data is registered one cycle after the read enable and held otherwise.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset the direction, output data, level-select, polarity, rising and falling enables and the enable register read 0x0000, the mask register (byte offset 0x28) reads 0xFFFF, and `irq` is 0.
- R2: The direction register at byte offset 0x00 is read/write; a bit of 1 makes that pin an output, and `pin_oe` equals the register from the cycle after the write.
- R3: A write to offset 0x18 sets only the output bits written as 1, a write to offset 0x1C clears only the bits written as 1; the output word reads back at offset 0x20 and drives `pin_out`. Both strobe offsets read as 0x0000.
- R4: Offset 0x14 returns `pin_in` after a two-flop synchronizer; `bus_rdata` is loaded on the clock edge where `bus_re` is 1 and holds its value while `bus_re` is 0.
- R5: With the level-select bit (offset 0x04) at 1, the polarity bit (offset 0x08) picks the active level, 1 high and 0 low, and the pending bit follows that level.
- R6: With level-select at 0, the rising enable (offset 0x0C) and falling enable (offset 0x10) act independently, both set detects both edges, and an edge event stays pending until acknowledged.
- R7: The masked status at offset 0x30 equals pending AND NOT mask (offset 0x28) AND enable (offset 0x2C).
- R8: Writing 1s to offset 0x34 acknowledges those pending bits; a level-sensitive pin whose level is still active is pending again one cycle later.
- R9: `irq` is the registered OR of all masked status bits, and stays 0 while the enable register is all zero.
- R10: Writes to read-only offsets (0x14, 0x20, 0x30) and unmapped offsets change nothing, and unmapped offsets read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Output values toward the pads |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong configuration bit shows up at the ports one cycle after the write, either on `pin_oe`/`pin_out` or on the next register read, so the bench reads back every register it writes. A detector in the wrong state or a stale pending bit appears as a wrong masked-status word and a wrong `irq` level three to four cycles after the pin changes, once the synchronizer, the edge compare and the pending and interrupt registers have passed it on. A lost edge event is caught by reading the status long after the pin returned to its idle level, and a level bit that fails to re-arm is caught by reading right after an acknowledge.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

    // Byte offsets of the register bank
    localparam logic [7:0] OFF_DIR   = 8'h00;
    localparam logic [7:0] OFF_LSEL  = 8'h04;
    localparam logic [7:0] OFF_POL   = 8'h08;
    localparam logic [7:0] OFF_RISE  = 8'h0C;
    localparam logic [7:0] OFF_FALL  = 8'h10;
    localparam logic [7:0] OFF_DIN   = 8'h14;
    localparam logic [7:0] OFF_SET   = 8'h18;
    localparam logic [7:0] OFF_CLR   = 8'h1C;
    localparam logic [7:0] OFF_DOUT  = 8'h20;
    localparam logic [7:0] OFF_MASK  = 8'h28;
    localparam logic [7:0] OFF_EN    = 8'h2C;
    localparam logic [7:0] OFF_MSTAT = 8'h30;
    localparam logic [7:0] OFF_ACK   = 8'h34;

    typedef enum logic [3:0] {
        RID_NONE, RID_DIR, RID_LSEL, RID_POL, RID_RISE, RID_FALL, RID_DIN,
        RID_SET, RID_CLR, RID_DOUT, RID_MASK, RID_EN, RID_MSTAT, RID_ACK
    } reg_id_e;

    typedef enum logic [1:0] {
        DET_EDGE     = 2'd0,
        DET_LEVEL_HI = 2'd1,
        DET_LEVEL_LO = 2'd2
    } det_mode_e;

endpackage

// File: rtl/pin_event_sync.sv
module pin_event_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pin_event_det.sv
module pin_event_det
    import pin_event_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    input  logic lsel,
    input  logic pol,
    input  logic rise_en,
    input  logic fall_en,
    input  logic ack,
    output logic pend
);
    det_mode_e mode;
    logic      prev_q;
    logic      pend_q;
    logic      pend_d;

    // Mode decode: the detector's state
    always_comb begin
        if (!lsel)    mode = DET_EDGE;
        else if (pol) mode = DET_LEVEL_HI;
        else          mode = DET_LEVEL_LO;
    end

    // Next pending value chosen by mode
    always_comb begin
        unique case (mode)
            DET_LEVEL_HI: pend_d = smp & ~ack;
            DET_LEVEL_LO: pend_d = ~smp & ~ack;
            DET_EDGE:     pend_d = (pend_q & ~ack)
                                 | (rise_en & smp & ~prev_q)
                                 | (fall_en & ~smp & prev_q);
            default:      pend_d = pend_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= smp;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
    import pin_event_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_re,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};

    reg_id_e          rid;
    logic [NPINS-1:0] dir_q, lsel_q, pol_q, rise_q, fall_q;
    logic [NPINS-1:0] mask_q, en_q, dout_q, rdata_q;
    logic [NPINS-1:0] din_s, pend, mstat, ack_w, rd_mux;
    logic             irq_q;

    // Address decode into a register identifier
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFF_DIR):   rid = RID_DIR;
            ADDR_W'(OFF_LSEL):  rid = RID_LSEL;
            ADDR_W'(OFF_POL):   rid = RID_POL;
            ADDR_W'(OFF_RISE):  rid = RID_RISE;
            ADDR_W'(OFF_FALL):  rid = RID_FALL;
            ADDR_W'(OFF_DIN):   rid = RID_DIN;
            ADDR_W'(OFF_SET):   rid = RID_SET;
            ADDR_W'(OFF_CLR):   rid = RID_CLR;
            ADDR_W'(OFF_DOUT):  rid = RID_DOUT;
            ADDR_W'(OFF_MASK):  rid = RID_MASK;
            ADDR_W'(OFF_EN):    rid = RID_EN;
            ADDR_W'(OFF_MSTAT): rid = RID_MSTAT;
            ADDR_W'(OFF_ACK):   rid = RID_ACK;
            default:            rid = RID_NONE;
        endcase
    end

    // Configuration and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            lsel_q <= '0;
            pol_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            mask_q <= ALL_ONES;
            en_q   <= '0;
            dout_q <= '0;
        end else if (bus_we) begin
            unique case (rid)
                RID_DIR:  dir_q  <= bus_wdata;
                RID_LSEL: lsel_q <= bus_wdata;
                RID_POL:  pol_q  <= bus_wdata;
                RID_RISE: rise_q <= bus_wdata;
                RID_FALL: fall_q <= bus_wdata;
                RID_MASK: mask_q <= bus_wdata;
                RID_EN:   en_q   <= bus_wdata;
                RID_SET:  dout_q <= dout_q | bus_wdata;
                RID_CLR:  dout_q <= dout_q & ~bus_wdata;
                default:  ;
            endcase
        end
    end

    assign ack_w = (bus_we && rid == RID_ACK) ? bus_wdata : '0;

    pin_event_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (din_s)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_det
        pin_event_det u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp     (din_s[p]),
            .lsel    (lsel_q[p]),
            .pol     (pol_q[p]),
            .rise_en (rise_q[p]),
            .fall_en (fall_q[p]),
            .ack     (ack_w[p]),
            .pend    (pend[p])
        );
    end

    assign mstat = pend & ~mask_q & en_q;

    // Read mux
    always_comb begin
        unique case (rid)
            RID_DIR:   rd_mux = dir_q;
            RID_LSEL:  rd_mux = lsel_q;
            RID_POL:   rd_mux = pol_q;
            RID_RISE:  rd_mux = rise_q;
            RID_FALL:  rd_mux = fall_q;
            RID_DIN:   rd_mux = din_s;
            RID_DOUT:  rd_mux = dout_q;
            RID_MASK:  rd_mux = mask_q;
            RID_EN:    rd_mux = en_q;
            RID_MSTAT: rd_mux = mstat;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (bus_re) rdata_q <= rd_mux;
            irq_q <= |mstat;
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = dout_q;
    assign pin_oe    = dir_q;
    assign irq       = irq_q;
endmodule

// File: rtl/pin_event_ctrl_chk.sv
module pin_event_ctrl_chk
    import pin_event_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NPINS-1:0]  bus_wdata,
    input logic              bus_re,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic [NPINS-1:0]  en_q
);
    assert_oe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_DIR)) |=> (pin_oe == $past(bus_wdata)));

    assert_set_only_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_SET)) |=> (pin_out == ($past(pin_out) | $past(bus_wdata))));

    assert_clr_only_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_CLR)) |=> (pin_out == ($past(pin_out) & ~$past(bus_wdata))));

    assert_out_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == ADDR_W'(OFF_SET) || bus_addr == ADDR_W'(OFF_CLR))) |=> $stable(pin_out));

    assert_rdata_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    assert_quiet_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq);
endmodule

bind pin_event_ctrl pin_event_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .en_q      (en_q)
);

// File: tb/test_pin_event_ctrl.sv
`timescale 1ns/1ps
module test_pin_event_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pin_event_ctrl i_pin_event_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Vector: {is_read, addr[7:0], wdata[15:0], expected[15:0]}
    localparam int NV = 18;
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 8'h00, 16'h00F0, 16'h0000},
        {1'b1, 8'h00, 16'h0000, 16'h00F0},  // R2
        {1'b0, 8'h18, 16'h0033, 16'h0000},
        {1'b1, 8'h20, 16'h0000, 16'h0033},  // R3
        {1'b0, 8'h18, 16'h0300, 16'h0000},
        {1'b1, 8'h20, 16'h0000, 16'h0333},  // R3
        {1'b0, 8'h1C, 16'h0011, 16'h0000},
        {1'b1, 8'h20, 16'h0000, 16'h0322},  // R3
        {1'b1, 8'h18, 16'h0000, 16'h0000},  // R3 strobe reads 0
        {1'b0, 8'h20, 16'hFFFF, 16'h0000},
        {1'b1, 8'h20, 16'h0000, 16'h0322},  // R10 read-only
        {1'b0, 8'h24, 16'hBEEF, 16'h0000},
        {1'b1, 8'h24, 16'h0000, 16'h0000},  // R10 unmapped
        {1'b0, 8'h08, 16'hA5A5, 16'h0000},
        {1'b1, 8'h08, 16'h0000, 16'hA5A5},  // R5 polarity rw
        {1'b0, 8'h08, 16'h0000, 16'h0000},
        {1'b0, 8'h0C, 16'h1234, 16'h0000},
        {1'b1, 8'h0C, 16'h0000, 16'h1234}   // R6 rise rw
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rdchk("R1 mask", 8'h28, 16'hFFFF);
        rdchk("R1 enable", 8'h2C, 16'h0000);
        rdchk("R1 dir", 8'h00, 16'h0000);
        rdchk("R1 lsel", 8'h04, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        chk("R1 pin_out", pin_out, 16'h0000);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][40]) rdchk($sformatf("vector %0d (R2/R3/R5/R6/R10)", i), VEC[i][39:32], VEC[i][15:0]);
            else            wr(VEC[i][39:32], VEC[i][31:16]);
        end
        wr(8'h0C, 16'h0000);
        chk("R2 pin_oe", pin_oe, 16'h00F0);
        chk("R3 pin_out", pin_out, 16'h0322);

        // R4 synchronized input
        pin_in = 16'h1234;
        idle(4);
        rdchk("R4 data-in", 8'h14, 16'h1234);
        idle(3);
        chk("R4 rdata held", bus_rdata, 16'h1234);
        wr(8'h34, 16'hFFFF);

        // R6 rising edge on pin 0
        wr(8'h28, 16'hFFFE);
        wr(8'h2C, 16'h0001);
        wr(8'h0C, 16'h0001);
        idle(2);
        rdchk("R6 no event yet", 8'h30, 16'h0000);
        pin_in[0] = 1'b1;
        idle(5);
        rdchk("R6 rise pending", 8'h30, 16'h0001);
        chk("R9 irq on", {15'd0, irq}, 16'h0001);
        pin_in[0] = 1'b0;
        idle(5);
        rdchk("R6 latched after fall (rise only)", 8'h30, 16'h0001);
        wr(8'h34, 16'h0001);
        idle(2);
        rdchk("R8 edge acked", 8'h30, 16'h0000);
        chk("R9 irq off", {15'd0, irq}, 16'h0000);

        // R6 both edges
        wr(8'h10, 16'h0001);
        pin_in[0] = 1'b1;
        idle(5);
        rdchk("R6 both: rise", 8'h30, 16'h0001);
        wr(8'h34, 16'h0001);
        idle(2);
        pin_in[0] = 1'b0;
        idle(5);
        rdchk("R6 both: fall", 8'h30, 16'h0001);
        wr(8'h34, 16'h0001);
        wr(8'h0C, 16'h0000);
        idle(2);
        pin_in[0] = 1'b1;
        idle(5);
        rdchk("R6 fall only ignores rise", 8'h30, 16'h0000);

        // R7 mask and enable on pin 1
        wr(8'h0C, 16'h0002);
        wr(8'h2C, 16'h0003);
        pin_in[1] = 1'b1;
        idle(5);
        rdchk("R7 masked pin hidden", 8'h30, 16'h0000);
        chk("R9 masked no irq", {15'd0, irq}, 16'h0000);
        wr(8'h28, 16'hFFFC);
        idle(1);
        rdchk("R7 unmasked shows latched", 8'h30, 16'h0002);
        wr(8'h2C, 16'h0001);
        idle(1);
        rdchk("R7 disabled hidden", 8'h30, 16'h0000);
        wr(8'h30, 16'hFFFF);
        wr(8'h2C, 16'h0003);
        idle(1);
        rdchk("R10 status write no clear", 8'h30, 16'h0002);
        wr(8'h34, 16'h0002);
        idle(1);
        rdchk("R8 pin1 acked", 8'h30, 16'h0000);

        // R5 level on pin 2 (pin_in bit2 is 1)
        wr(8'h04, 16'h0004);
        wr(8'h08, 16'h0004);
        wr(8'h2C, 16'h0004);
        wr(8'h28, 16'hFFFB);
        idle(2);
        rdchk("R5 level high pending", 8'h30, 16'h0004);
        wr(8'h34, 16'h0004);
        rdchk("R8 level re-asserts", 8'h30, 16'h0004);
        wr(8'h08, 16'h0000);
        idle(2);
        rdchk("R5 active-low inactive", 8'h30, 16'h0000);
        pin_in[2] = 1'b0;
        idle(5);
        rdchk("R5 active-low active", 8'h30, 16'h0004);
        chk("R9 level irq", {15'd0, irq}, 16'h0001);
        pin_in[2] = 1'b1;
        idle(5);
        rdchk("R5 follows level off", 8'h30, 16'h0000);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        rdchk("R1 mask after reset", 8'h28, 16'hFFFF);
        rdchk("R1 dout after reset", 8'h20, 16'h0000);
        chk("R1 pin_oe after reset", pin_oe, 16'h0000);

        finish_run();
    end
endmodule